// File: doc/BRIEF.md
# Watchdog and Reset Sequencer

This block produces the chip reset. Two sources feed it: an active-high external reset pin and a fixed-period watchdog. Firmware must service the watchdog regularly. All timing runs in the domain of a fast system clock. The 32.768 kHz crystal time base enters as a one-cycle strobe, `slow_tick_i`, issued once per crystal period. The pin is synchronised and then filtered by a counter on the fast clock, so that short glitches never reset the chip. The watchdog interval and the release delay are counted in crystal ticks.

The processor reset `cpu_rst_o` is held while the filtered pin is high. After the last source goes away, it stays held for a fixed number of crystal ticks. `cfg_clr_o` clears the configuration registers. It is driven only for a reset that came from the pin or from power-on, so a watchdog reset leaves configuration intact. A debug-enable input stops the watchdog. A sticky flag records that a watchdog reset occurred. Only a pin reset clears the flag.

With the default parameters, the watchdog allows 49152 ticks (1.5 s) between kicks. The release delay is 4096 ticks (125 ms). The pin must stay high for 200 fast cycles, which is 1 µs at 200 MHz.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_ni` is low and until release, `cpu_rst_o`=1, `cfg_clr_o`=1 and `wdog_cause_o`=0. After `rst_ni` rises, `cpu_rst_o` falls on the RELEASE_CYC-th `slow_tick_i` strobe.
- R2: A pin pulse shorter than FILT_CYC fast cycles has no effect on any output. A pulse of at least FILT_CYC cycles raises `cpu_rst_o` within FILT_CYC+4 cycles after the pin rises.
- R3: While the filtered pin is high, `cpu_rst_o` stays 1 whatever the tick and kick activity.
- R4: After the filtered pin goes low, `cpu_rst_o` falls on the edge that samples the RELEASE_CYC-th tick strobe, counting from the first strobe after the filter output drops.
- R5: `cfg_clr_o` is 1 throughout a pin reset, including its release wait. It is 0 throughout a watchdog reset.
- R6: Out of reset, with `dbg_en_i`=0 and no kick, the WDOG_LIMIT-th tick raises `cpu_rst_o`. WDOG_LIMIT-1 ticks do not.
- R7: A `kick_i` pulse restarts the watchdog interval from zero, including when it arrives in the same cycle as a tick.
- R8: A watchdog reset is released on its RELEASE_CYC-th tick, exactly like a pin reset.
- R9: While `dbg_en_i`=1 the watchdog never fires and its count stays at zero. After `dbg_en_i` falls, a full WDOG_LIMIT ticks are needed to fire.
- R10: `wdog_cause_o` is set by a watchdog reset and stays set through later watchdog resets and normal running. Only an accepted pin reset clears it.
- R11: The watchdog count is held at zero while `cpu_rst_o` is high, so after any release a full WDOG_LIMIT ticks are needed to fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| slow_tick_i | input | 1 | One-cycle strobe per 32.768 kHz crystal period |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| dbg_en_i | input | 1 | Debug enable; disables the watchdog |
| kick_i | input | 1 | Watchdog refresh pulse |
| cpu_rst_o | output | 1 | Processor reset, active high |
| cfg_clr_o | output | 1 | Configuration register clear, active high |
| wdog_cause_o | output | 1 | Sticky flag: last reset came from the watchdog |

## Verification
A watchdog count that is wrong by even one tick shows up at `cpu_rst_o` on the very tick where the firing point should or should not be. For that reason the bench samples the port after every tick at the limit boundaries. A release counter that is off by one makes `cpu_rst_o` fall one tick early or late, and this is checked tick by tick around RELEASE_CYC. A wrong record of which source caused the reset appears immediately as a wrong `cfg_clr_o` or `wdog_cause_o` during the hold. A filter threshold that is off by one appears within a few cycles of a pulse that is exactly FILT_CYC or FILT_CYC-1 cycles wide.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PIN  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  typedef enum logic {
    SRC_PIN  = 1'b0,
    SRC_WDOG = 1'b1
  } rst_src_e;
endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_act_o
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam logic [FW-1:0] FULL = FW'(FILT_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FW-1:0]          cnt_q;
  logic                   pin_s;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  // level must persist FILT_CYC cycles; any low sample restarts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!pin_s)      cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign pin_act_o = (cnt_q == FULL);
endmodule

// File: rtl/rstseq_wdog.sv
module rstseq_wdog #(
  parameter int WDOG_LIMIT = 49152
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic kick_i,
  input  logic hold_i,
  output logic fire_o
);
  localparam int WW = (WDOG_LIMIT > 1) ? $clog2(WDOG_LIMIT) : 1;
  localparam logic [WW-1:0] LAST = WW'(WDOG_LIMIT - 1);

  logic [WW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign fire_o  = tick_i && at_last && !hold_i && !kick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (hold_i || kick_i) cnt_q <= '0;
    else if (tick_i)           cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rstseq_seq.sv
module rstseq_seq
  import rstseq_pkg::*;
#(
  parameter int RELEASE_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_act_i,
  input  logic wdog_fire_i,
  output logic cpu_rst_o,
  output logic cfg_clr_o,
  output logic wdog_cause_o
);
  localparam int RW = (RELEASE_CYC > 1) ? $clog2(RELEASE_CYC) : 1;
  localparam logic [RW-1:0] REL_LAST = RW'(RELEASE_CYC - 1);

  seq_state_e    state_q;
  rst_src_e      src_q;
  logic          cause_q;
  logic [RW-1:0] rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      src_q   <= SRC_PIN;
      cause_q <= 1'b0;
      rel_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (pin_act_i) begin
            state_q <= ST_PIN;
            src_q   <= SRC_PIN;
            cause_q <= 1'b0;
          end else if (wdog_fire_i) begin
            state_q <= ST_WAIT;
            src_q   <= SRC_WDOG;
            cause_q <= 1'b1;
            rel_q   <= '0;
          end
        end
        ST_PIN: begin
          if (!pin_act_i) begin
            state_q <= ST_WAIT;
            rel_q   <= '0;
          end
        end
        ST_WAIT: begin
          if (pin_act_i) begin
            state_q <= ST_PIN;
            src_q   <= SRC_PIN;
            cause_q <= 1'b0;
          end else if (tick_i) begin
            if (rel_q == REL_LAST) state_q <= ST_RUN;
            else                   rel_q   <= rel_q + 1'b1;
          end
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  assign cpu_rst_o    = (state_q != ST_RUN);
  assign cfg_clr_o    = (state_q == ST_PIN) || (state_q == ST_WAIT && src_q == SRC_PIN);
  assign wdog_cause_o = cause_q;
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 200,
  parameter int WDOG_LIMIT  = 49152,
  parameter int RELEASE_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_tick_i,
  input  logic rst_pin_i,
  input  logic dbg_en_i,
  input  logic kick_i,
  output logic cpu_rst_o,
  output logic cfg_clr_o,
  output logic wdog_cause_o
);
  logic pin_act;
  logic wdog_fire;
  logic wdog_hold;

  rstseq_pin_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_CYC   (FILT_CYC)
  ) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (rst_pin_i),
    .pin_act_o(pin_act)
  );

  assign wdog_hold = cpu_rst_o || dbg_en_i;

  rstseq_wdog #(
    .WDOG_LIMIT(WDOG_LIMIT)
  ) u_wdog (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(slow_tick_i),
    .kick_i(kick_i),
    .hold_i(wdog_hold),
    .fire_o(wdog_fire)
  );

  rstseq_seq #(
    .RELEASE_CYC(RELEASE_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (slow_tick_i),
    .pin_act_i   (pin_act),
    .wdog_fire_i (wdog_fire),
    .cpu_rst_o   (cpu_rst_o),
    .cfg_clr_o   (cfg_clr_o),
    .wdog_cause_o(wdog_cause_o)
  );
endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic slow_tick_i,
  input logic dbg_en_i,
  input logic kick_i,
  input logic pin_act,
  input logic wdog_fire,
  input logic cpu_rst_o,
  input logic cfg_clr_o,
  input logic wdog_cause_o
);
  p_pin_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_act |=> cpu_rst_o && cfg_clr_o && !wdog_cause_o);

  p_release_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_o) |-> $past(slow_tick_i));

  p_clr_from_pin_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_clr_o) |-> $past(pin_act));

  p_wdog_keeps_cfg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_fire && !pin_act |=> cpu_rst_o && !cfg_clr_o && wdog_cause_o);

  p_kick_restarts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !wdog_fire);

  p_dbg_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_en_i && !pin_act && !cpu_rst_o |=> !cpu_rst_o);

  p_cause_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_cause_o && !pin_act |=> wdog_cause_o);
endmodule

bind rstseq_top rstseq_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slow_tick_i (slow_tick_i),
  .dbg_en_i    (dbg_en_i),
  .kick_i      (kick_i),
  .pin_act     (pin_act),
  .wdog_fire   (wdog_fire),
  .cpu_rst_o   (cpu_rst_o),
  .cfg_clr_o   (cfg_clr_o),
  .wdog_cause_o(wdog_cause_o)
);

// File: tb/rstseq_top_tb.sv
`timescale 1ns/1ps
module rstseq_top_tb;
  localparam int F = 6;
  localparam int L = 40;
  localparam int R = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic slow_tick_i = 1'b0, rst_pin_i = 1'b0, dbg_en_i = 1'b0, kick_i = 1'b0;
  logic cpu_rst_o, cfg_clr_o, wdog_cause_o;
  int n_chk = 0, n_fail = 0, mcnt = 0, seed_v;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rstseq_top #(.SYNC_STAGES(2), .FILT_CYC(F), .WDOG_LIMIT(L), .RELEASE_CYC(R)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .slow_tick_i(slow_tick_i), .rst_pin_i(rst_pin_i),
    .dbg_en_i(dbg_en_i), .kick_i(kick_i), .cpu_rst_o(cpu_rst_o), .cfg_clr_o(cfg_clr_o),
    .wdog_cause_o(wdog_cause_o));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input logic with_kick);
    slow_tick_i = 1'b1; kick_i = with_kick;
    @(negedge clk);
    slow_tick_i = 1'b0; kick_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick(1'b0);
  endtask

  task automatic kick();
    kick_i = 1'b1; @(negedge clk); kick_i = 1'b0; @(negedge clk);
  endtask

  task automatic pin_pulse(input int w);
    rst_pin_i = 1'b1; idle(w); rst_pin_i = 1'b0;
  endtask

  // exactly R ticks needed: high after R-1, low after R
  task automatic release_check(input string req);
    ticks(R - 1);
    chk(req, cpu_rst_o, 1'b1);
    tick(1'b0);
    chk(req, cpu_rst_o, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog timeout");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'd4711);
    idle(3);
    chk("R1 rst", cpu_rst_o, 1'b1);
    chk("R1 clr", cfg_clr_o, 1'b1);
    chk("R1 cause", wdog_cause_o, 1'b0);
    rst_ni = 1'b1;
    idle(2);
    chk("R1 clr after por", cfg_clr_o, 1'b1);
    release_check("R1 por release");

    // R6/R11: full interval after release
    ticks(L - 1);
    chk("R6 R11 no fire at L-1", cpu_rst_o, 1'b0);
    tick(1'b0);
    chk("R6 fire at L", cpu_rst_o, 1'b1);
    chk("R5 wdog keeps cfg", cfg_clr_o, 1'b0);
    chk("R10 cause set", wdog_cause_o, 1'b1);
    ticks(R - 1);
    chk("R5 cfg low in wdog wait", cfg_clr_o, 1'b0);
    tick(1'b0);
    chk("R8 wdog release", cpu_rst_o, 1'b0);
    chk("R10 cause after release", wdog_cause_o, 1'b1);

    // R7 kick
    ticks(L - 5);
    kick();
    ticks(L - 1);
    chk("R7 kick restart", cpu_rst_o, 1'b0);
    tick(1'b1);
    ticks(L - 1);
    chk("R7 kick with tick", cpu_rst_o, 1'b0);
    tick(1'b0);
    chk("R7 fire after kick+tick", cpu_rst_o, 1'b1);
    chk("R10 cause stays on second wdog", wdog_cause_o, 1'b1);
    release_check("R8 second release");

    // R9 debug
    ticks(L - 3);
    dbg_en_i = 1'b1;
    ticks(3 * L);
    chk("R9 dbg blocks", cpu_rst_o, 1'b0);
    dbg_en_i = 1'b0;
    idle(1);
    ticks(L - 1);
    chk("R9 held zero in dbg", cpu_rst_o, 1'b0);
    kick();

    // R7 random kicks
    mcnt = 0;
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 4;
      if (r == 0 && mcnt == L - 1) r = 1;
      case (r)
        0: begin tick(1'b0); mcnt++; end
        1: begin kick(); mcnt = 0; end
        2: begin tick(1'b1); mcnt = 0; end
        default: idle(1);
      endcase
      if (cpu_rst_o !== 1'b0) chk("R7 random kick run", cpu_rst_o, 1'b0);
      else n_chk++;
    end
    // finish interval from model count
    ticks(L - 1 - mcnt);
    chk("R7 model count L-1", cpu_rst_o, 1'b0);
    tick(1'b0);
    chk("R7 model count L", cpu_rst_o, 1'b1);
    release_check("R8 third release");

    // R2 glitches
    for (int i = 0; i < 30; i++) begin
      pin_pulse(1 + ($urandom % (F - 1)));
      idle(4);
      chk("R2 glitch rst", cpu_rst_o, 1'b0);
      chk("R2 glitch cause", wdog_cause_o, 1'b1);
    end
    pin_pulse(F - 1);
    idle(6);
    chk("R2 F-1 ignored", cpu_rst_o, 1'b0);
    pin_pulse(F);
    idle(4);
    chk("R2 F accepted", cpu_rst_o, 1'b1);
    chk("R5 pin clr", cfg_clr_o, 1'b1);
    chk("R10 pin clears cause", wdog_cause_o, 1'b0);

    // R3 held, R4 release
    rst_pin_i = 1'b1;
    idle(F + 4);
    ticks(3 * R);
    chk("R3 held while pin high", cpu_rst_o, 1'b1);
    rst_pin_i = 1'b0;
    idle(6);
    ticks(R - 1);
    chk("R4 held at R-1", cpu_rst_o, 1'b1);
    chk("R5 clr in pin wait", cfg_clr_o, 1'b1);
    tick(1'b0);
    chk("R4 release at R", cpu_rst_o, 1'b0);
    chk("R5 clr off", cfg_clr_o, 1'b0);

    // R10 pin during wdog wait
    ticks(L);
    chk("R10 wdog again", wdog_cause_o, 1'b1);
    pin_pulse(F + 2);
    idle(6);
    chk("R10 pin in wdog wait", wdog_cause_o, 1'b0);
    chk("R5 pin in wdog wait", cfg_clr_o, 1'b1);
    release_check("R4 after override");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule